// File: doc/BRIEF.md
# Low-Precision Linear Model Trainer

This block trains a dense linear model with stochastic gradient descent. Each training sample arrives as one wide input beat. The beat carries K signed integer features packed side by side, plus a signed label. The model weights sit in registers inside the block. For every accepted sample the block multiplies each feature by its weight and sums the products in a pipelined adder tree. It subtracts the label from that sum and scales the difference by the step size. The step size is a power of two, so the scaling is an arithmetic right shift. The resulting scalar is multiplied back by every feature, and the products are summed into one gradient accumulator per feature lane.

Weights change only at a batch boundary. At that point each weight has its accumulated gradient subtracted, and the accumulators are cleared. Samples stream back to back inside a batch. The input stalls only while the sample that closes a batch travels through the pipeline and its weight update is written. A beat marked as final closes whatever batch is open. Once the update for that beat has been written, the block raises a completion flag, and the trained weights can then be read one at a time by index. Before training starts, weights can be preset through a load port.

Top module: `sgdq_engine`

## Requirements
- R1: A beat holds K = LINE_W/FEAT_W two's-complement features. Feature j is at bits [j*FEAT_W +: FEAT_W] of `in_line`, and `in_label` is a 32-bit signed label. With the defaults (LINE_W=512, FEAT_W=8), K is 32.
- R2: The forward sum is the exact sum over j of feature j times weight j, with no rounding or saturation. It uses the weights as they stood when the sample was accepted.
- R3: The gradient scalar is g = sat32((sum - label) >>> cfg_shift), an arithmetic shift. sat32 clamps to the range [-2^31, 2^31-1].
- R4: Each lane accumulates acc_j = sat32(acc_j + g * feature_j) once per accepted sample.
- R5: When the number of samples accepted since the last update reaches `cfg_batch`, every weight becomes w_j = sat32(w_j - acc_j), and every acc_j is cleared. Until then the weights do not change. A `cfg_batch` of 0 behaves as 1.
- R6: A beat accepted with `in_last`=1 closes the open batch, even if the batch is shorter than `cfg_batch`.
- R7: `in_ready` goes low in the cycle after a batch-closing beat is accepted. It stays low until that batch's weight update has been written, and no beat is accepted while it is low.
- R8: `done` rises in the cycle after the update caused by an `in_last` beat. It is cleared by any accepted beat or any load write, and it otherwise holds its value.
- R9: With `ld_en`=1 while no sample is in flight, weight `ld_idx` takes the value `ld_val` at the clock edge.
- R10: `rd_data` is registered. One cycle after `rd_idx` is presented, it shows weight `rd_idx` if `done` is 1, and zero otherwise.
- R11: After reset, every weight and accumulator is zero, `in_ready` is 1, `done` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | SHIFT_W | Right-shift amount that encodes the step size |
| cfg_batch | input | BATCH_W | Number of samples per weight update (0 behaves as 1) |
| in_valid | input | 1 | Sample beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_line | input | LINE_W | Packed signed features |
| in_label | input | 32 | Signed label |
| in_last | input | 1 | Final beat of training |
| ld_en | input | 1 | Weight preset strobe |
| ld_idx | input | IDX_W | Weight index to preset |
| ld_val | input | 32 | Preset value |
| rd_idx | input | IDX_W | Weight index to read |
| rd_data | output | 32 | Weight value (zero while not done) |
| done | output | 1 | Training complete flag |

## Verification
A wrong internal value anywhere in this block ends up in the weights, for example a misaligned label in the pipeline, a wrong shift direction, a missed saturation, or an accumulator that is not cleared. Such a fault therefore shows in `rd_data` once `done` rises, which is at most a few tens of cycles after the final beat. Because each batch's update feeds the next batch's forward sum, an error early in a run also spreads into later weights. Errors in handshake state are visible sooner: `in_ready` must fall exactly one cycle after a closing beat is accepted, and `done` must follow the final update and be cleared by the next accepted beat.

// File: rtl/sgdq_pkg.sv
package sgdq_pkg;

    localparam int WORD_W = 32;
    localparam int WIDE_W = 64;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    // Sideband that travels with each sample through the pipeline
    typedef struct packed {
        logic  vld;
        logic  close;
        logic  last;
        word_t label;
    } tag_t;

    localparam wide_t WORD_MAX = (wide_t'(1) <<< (WORD_W-1)) - wide_t'(1);
    localparam wide_t WORD_MIN = -(wide_t'(1) <<< (WORD_W-1));

    function automatic word_t sat_word(input wide_t v);
        if (v > WORD_MAX) return word_t'(WORD_MAX);
        if (v < WORD_MIN) return word_t'(WORD_MIN);
        return word_t'(v);
    endfunction

endpackage

// File: rtl/sgdq_mul_lane.sv
module sgdq_mul_lane
    import sgdq_pkg::*;
#(
    parameter int FEAT_W = 8
) (
    input  logic                     clk,
    input  logic signed [FEAT_W-1:0] feat,
    input  word_t                    weight,
    output wide_t                    prod
);

    always_ff @(posedge clk) begin
        prod <= wide_t'(feat) * wide_t'(weight);
    end

endmodule

// File: rtl/sgdq_add_tree.sv
module sgdq_add_tree
    import sgdq_pkg::*;
#(
    parameter int N = 32
) (
    input  logic  clk,
    input  wide_t leaf [N],
    output wide_t sum
);

    localparam int LVLS = $clog2(N);

    genvar lv;
    generate
        for (lv = 0; lv < LVLS; lv++) begin : g_lvl
            localparam int CNT = N >> (lv + 1);
            wide_t s [CNT];
            if (lv == 0) begin : g_first
                always_ff @(posedge clk) begin
                    for (int n = 0; n < CNT; n++) begin
                        s[n] <= leaf[2*n] + leaf[2*n+1];
                    end
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    for (int n = 0; n < CNT; n++) begin
                        s[n] <= g_lvl[lv-1].s[2*n] + g_lvl[lv-1].s[2*n+1];
                    end
                end
            end
        end
    endgenerate

    assign sum = g_lvl[LVLS-1].s[0];

endmodule

// File: rtl/sgdq_grad_lane.sv
module sgdq_grad_lane
    import sgdq_pkg::*;
#(
    parameter int FEAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_we,
    input  word_t                    ld_val,
    input  logic                     step,
    input  logic                     close,
    input  word_t                    g,
    input  logic signed [FEAT_W-1:0] feat,
    output word_t                    weight
);

    word_t acc_q;
    word_t w_q;
    word_t acc_nxt;

    always_comb begin
        acc_nxt = sat_word(wide_t'(acc_q) + wide_t'(g) * wide_t'(feat));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            w_q   <= '0;
        end else if (ld_we) begin
            w_q <= ld_val;
        end else if (step) begin
            if (close) begin
                w_q   <= sat_word(wide_t'(w_q) - wide_t'(acc_nxt));
                acc_q <= '0;
            end else begin
                acc_q <= acc_nxt;
            end
        end
    end

    assign weight = w_q;

endmodule

// File: rtl/sgdq_engine.sv
module sgdq_engine
    import sgdq_pkg::*;
#(
    parameter int LINE_W  = 512,
    parameter int FEAT_W  = 8,
    parameter int BATCH_W = 16,
    parameter int SHIFT_W = 5,
    localparam int K      = LINE_W / FEAT_W,
    localparam int IDX_W  = $clog2(K)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [BATCH_W-1:0] cfg_batch,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LINE_W-1:0]  in_line,
    input  logic [31:0]        in_label,
    input  logic               in_last,
    input  logic               ld_en,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [31:0]        ld_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_data,
    output logic               done
);

    localparam int TREE_L = $clog2(K);
    localparam int DEPTH  = TREE_L + 3;

    tag_t              tag_q  [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    word_t             weight [K];
    wide_t             prod   [K];
    wide_t             dot;
    word_t             g_q;
    logic              hold_q;
    logic              done_q;
    logic [BATCH_W-1:0] cnt_q;
    logic [BATCH_W:0]   cnt_inc;
    logic [BATCH_W:0]   eff_batch;
    logic              accept;
    logic              closing;
    logic              upd;
    logic              step;

    assign in_ready  = !hold_q;
    assign accept    = in_valid && !hold_q;
    assign cnt_inc   = {1'b0, cnt_q} + (BATCH_W+1)'(1);
    assign eff_batch = (cfg_batch == '0) ? (BATCH_W+1)'(1) : {1'b0, cfg_batch};
    assign closing   = in_last || (cnt_inc >= eff_batch);
    assign step      = tag_q[DEPTH-1].vld;
    assign upd       = step && tag_q[DEPTH-1].close;

    // Label and feature delay lines run beside the multiply/add pipeline
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else begin
            tag_q[0] <= '{vld: accept, close: closing, last: in_last,
                          label: word_t'(in_label)};
            for (int i = 1; i < DEPTH; i++) tag_q[i] <= tag_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        line_q[0] <= in_line;
        for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end

    // Batch counter and input stall
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            if (accept) begin
                cnt_q <= closing ? '0 : cnt_inc[BATCH_W-1:0];
                if (closing) hold_q <= 1'b1;
            end else if (upd) begin
                hold_q <= 1'b0;
            end
        end
    end

    // Gradient scalar: (sum - label) scaled by a power-of-two step
    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= '0;
        end else begin
            g_q <= sat_word((dot - wide_t'($signed(tag_q[DEPTH-2].label))) >>> cfg_shift);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rd_data <= '0;
        end else begin
            if (accept || ld_en) done_q <= 1'b0;
            else if (upd && tag_q[DEPTH-1].last) done_q <= 1'b1;
            rd_data <= done_q ? weight[rd_idx] : '0;
        end
    end

    assign done = done_q;

    genvar j;
    generate
        for (j = 0; j < K; j++) begin : g_lane
            logic signed [FEAT_W-1:0] f_head;
            logic signed [FEAT_W-1:0] f_tail;
            assign f_head = line_q[0][j*FEAT_W +: FEAT_W];
            assign f_tail = line_q[DEPTH-1][j*FEAT_W +: FEAT_W];

            sgdq_mul_lane #(.FEAT_W(FEAT_W)) u_mul (
                .clk    (clk),
                .feat   (f_head),
                .weight (weight[j]),
                .prod   (prod[j])
            );

            sgdq_grad_lane #(.FEAT_W(FEAT_W)) u_grad (
                .clk    (clk),
                .rst    (rst),
                .ld_we  (ld_en && (ld_idx == IDX_W'(j))),
                .ld_val (word_t'(ld_val)),
                .step   (step),
                .close  (tag_q[DEPTH-1].close),
                .g      (g_q),
                .feat   (f_tail),
                .weight (weight[j])
            );
        end
    endgenerate

    sgdq_add_tree #(.N(K)) u_tree (
        .clk  (clk),
        .leaf (prod),
        .sum  (dot)
    );

endmodule

// File: rtl/sgdq_engine_chk.sv
module sgdq_engine_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic in_last,
    input logic ld_en,
    input logic done
);

    p_last_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    p_accept_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !done);

    p_stall_not_done_r8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !done);

    p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !in_valid && !ld_en) |=> done);

    p_done_after_update_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(!in_ready));

    p_reset_ready_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !done));

endmodule

bind sgdq_engine sgdq_engine_chk u_chk (.*);

// File: tb/sgdq_engine_tb.sv
module sgdq_engine_tb;

    localparam int K  = 32;
    localparam int FW = 8;
    localparam int LW = 512;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    cfg_shift;
    logic [15:0]   cfg_batch;
    logic          in_valid;
    logic          in_ready;
    logic [LW-1:0] in_line;
    logic [31:0]   in_label;
    logic          in_last;
    logic          ld_en;
    logic [4:0]    ld_idx;
    logic [31:0]   ld_val;
    logic [4:0]    rd_idx;
    logic [31:0]   rd_data;
    logic          done;

    int     n_chk = 0;
    int     n_bad = 0;
    int     sf   [NS][K];
    longint slab [NS];
    longint rm   [K];

    always #10 clk = ~clk;

    sgdq_engine u_dut (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_batch(cfg_batch),
        .in_valid(in_valid), .in_ready(in_ready), .in_line(in_line),
        .in_label(in_label), .in_last(in_last), .ld_en(ld_en),
        .ld_idx(ld_idx), .ld_val(ld_val), .rd_idx(rd_idx),
        .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    // Reference trainer built from R2..R6
    task automatic ref_run(input int n, input int batch, input int shift);
        longint acc [K];
        int     eb;
        int     cnt;
        longint dot;
        longint g;
        eb  = (batch == 0) ? 1 : batch;
        cnt = 0;
        for (int j = 0; j < K; j++) acc[j] = 0;
        for (int s = 0; s < n; s++) begin
            dot = 0;
            for (int j = 0; j < K; j++) dot += longint'(sf[s][j]) * rm[j];
            g = sat32((dot - slab[s]) >>> shift);
            for (int j = 0; j < K; j++) acc[j] = sat32(acc[j] + g * longint'(sf[s][j]));
            cnt++;
            if (cnt >= eb || s == n - 1) begin
                for (int j = 0; j < K; j++) begin
                    rm[j]  = sat32(rm[j] - acc[j]);
                    acc[j] = 0;
                end
                cnt = 0;
            end
        end
    endtask

    task automatic load_all(input longint v [K]);
        for (int j = 0; j < K; j++) begin
            @(negedge clk);
            ld_en  = 1'b1;
            ld_idx = 5'(j);
            ld_val = 32'(v[j]);
            rm[j]  = v[j];
        end
        @(negedge clk);
        ld_en  = 1'b0;
        rd_idx = 5'd3;
        @(negedge clk);
        chk("R10 read while not done", longint'($signed(rd_data)), 0);
    endtask

    task automatic run(input string tag, input int n, input int batch, input int shift);
        int eb;
        int cnt;
        int guard;
        bit cl;
        eb  = (batch == 0) ? 1 : batch;
        cnt = 0;
        cfg_batch = 16'(batch);
        cfg_shift = 5'(shift);
        @(negedge clk);
        for (int s = 0; s < n; s++) begin
            for (int j = 0; j < K; j++) in_line[j*FW +: FW] = 8'(sf[s][j]);
            in_label = 32'(slab[s]);
            in_last  = (s == n - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            cnt++;
            cl = (cnt >= eb) || (s == n - 1);
            @(negedge clk);
            if (s == 0) chk("R8 accept clears done", longint'(done), 0);
            if (cl) begin
                chk("R7 stall after closing beat", longint'(in_ready), 0);
                cnt = 0;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 done after final update", longint'(done), 1);
        ref_run(n, batch, shift);
        for (int j = 0; j < K; j++) begin
            rd_idx = 5'(j);
            @(negedge clk);
            chk({tag, " weight R5"}, longint'($signed(rd_data)), rm[j]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        longint init [K];
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_line = '0; in_label = '0; in_last = 1'b0;
        ld_en = 1'b0; ld_idx = '0; ld_val = '0; rd_idx = '0;
        cfg_shift = '0; cfg_batch = 16'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 ready after reset", longint'(in_ready), 1);
        chk("R11 done after reset", longint'(done), 0);
        chk("R11 rd_data after reset", longint'($signed(rd_data)), 0);

        // R1 R2 R3 R11: directed samples on the reset (zero) model, batch of one
        for (int j = 0; j < K; j++) rm[j] = 0;
        for (int s = 0; s < 3; s++) begin
            for (int j = 0; j < K; j++) sf[s][j] = (j % 5) - 2 + s;
            slab[s] = 100 * (s + 1);
        end
        run("A R1 R2 R3 R11", 3, 1, 0);

        // R4 R5 R9: random preset, batch of four, streamed back to back
        for (int j = 0; j < K; j++) init[j] = longint'($urandom_range(0, 100)) - 50;
        load_all(init);
        for (int s = 0; s < 12; s++) begin
            for (int j = 0; j < K; j++) sf[s][j] = int'($urandom_range(0, 16)) - 8;
            slab[s] = longint'($urandom_range(0, 4000)) - 2000;
        end
        run("B R4 R9", 12, 4, 3);

        // R6: final batch shorter than the configured size
        for (int j = 0; j < K; j++) init[j] = longint'($urandom_range(0, 20)) - 10;
        load_all(init);
        for (int s = 0; s < 7; s++) begin
            for (int j = 0; j < K; j++) sf[s][j] = int'($urandom_range(0, 254)) - 127;
            slab[s] = longint'($urandom_range(0, 200000)) - 100000;
        end
        run("C R6", 7, 5, 2);

        // R5: batch size zero acts as one
        run("D R5 zero batch", 3, 0, 1);

        // R3 R4 R5: saturation at every clamp point
        for (int j = 0; j < K; j++) init[j] = (j % 2 == 0) ? 64'sd1073741824 : -64'sd2147483648;
        load_all(init);
        for (int s = 0; s < 3; s++) begin
            for (int j = 0; j < K; j++) sf[s][j] = (j % 2 == 0) ? 127 : -128;
            slab[s] = (s == 1) ? 64'sd2147483647 : -64'sd2147483648;
        end
        run("E R3 R4 saturate", 3, 2, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule